// File: doc/BRIEF.md
# Control Endpoint Event Flags and Status-Stage Reply

This block holds the interrupt flags and the completion control of a USB control endpoint, seen from a microcontroller byte bus. Single-cycle event strobes arrive from the serial interface engine. They cover a SETUP token seen, the SETUP buffer filled, a data buffer ready, the status handshake sent, a transfer error, and IN and OUT tokens. The block follows the control transfer through its stages, keeps five sticky flags, and tells the engine whether to answer the status stage with NAK or with a zero-length/ACK handshake.

Firmware clears a flag by writing 0 to it. It allows the transfer to finish by setting the completion enable. A new SETUP token withdraws that permission and also drops the error flag. The move into the status stage is found by watching for a token whose direction is opposite to the data stage. That move raises its own flag only while completion is still withheld, so firmware learns that the host is waiting on it.

Top module: `ctl_ep_events`

## Requirements
- R1: After reset both registers read 0x00, `irq` is 0, `status_ack` is 0 and `in_status` is 0.
- R2: The control register (address 0) stores the completion enable in bit 0 only. Bits 7:1 always read 0.
- R3: `status_ack` is 1 exactly when the completion enable is 1 and `resp_mode` equals 2'b01. Otherwise the status reply is NAK (`status_ack` = 0).
- R4: A SETUP token clears the completion enable, even against a write of 1 in the same cycle. It also clears the error flag (bit 4) unless an error strobe arrives in that same cycle. The other flags are untouched.
- R5: The flag register (address 1) sets bit 0 on a buffer-ready strobe, bit 1 on a status-handshake-sent strobe, bit 3 on a SETUP-buffer-ready strobe and bit 4 on an error strobe.
- R6: A write to the flag register clears each flag whose written bit is 0 and leaves the others unchanged. Writing 1 never sets a flag. Bits 7:5 read 0.
- R7: When a hardware set and a clear hit the same flag in the same cycle, the flag ends up set.
- R8: With completion disabled, bit 2 sets when an IN token arrives during the OUT data stage of a control write (`sie_dir_in`=0, `sie_len_zero`=0 at SETUP-buffer-ready). It also sets when an OUT token arrives during the IN data stage of a control read (`sie_dir_in`=1, `sie_len_zero`=0).
- R9: Bit 2 stays clear when completion is enabled, for a no-data transfer (`sie_len_zero`=1), and for a token whose direction matches the data stage.
- R10: `in_status` goes to 1 on the opposite-direction token in a data stage, or right after SETUP-buffer-ready for a no-data transfer. It drops after the status handshake is sent, and on a new SETUP token.
- R11: `irq` is the OR of the flags selected by `IRQ_MASK`. By default all five are selected.
- R12: `bus_rdata` is registered: it shows the register addressed in the previous cycle. Unmapped addresses read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sie_setup_tok | input | 1 | SETUP token received strobe |
| sie_setup_rdy | input | 1 | SETUP buffer ready strobe |
| sie_dir_in | input | 1 | Data direction of the request, 1 = device to host, valid with `sie_setup_rdy` |
| sie_len_zero | input | 1 | Request has no data stage, valid with `sie_setup_rdy` |
| sie_buf_rdy | input | 1 | Data buffer ready strobe |
| sie_hs_sent | input | 1 | Status-stage zero-length/ACK handshake sent strobe |
| sie_err | input | 1 | Transfer error strobe |
| sie_tok_in | input | 1 | IN token strobe |
| sie_tok_out | input | 1 | OUT token strobe |
| resp_mode | input | 2 | Endpoint response mode, 2'b01 = normal |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| status_ack | output | 1 | 1 = answer status stage with zero-length/ACK, 0 = NAK |
| in_status | output | 1 | Transfer is in its status stage |

## Verification
The hardest case to reach is the status-stage transition flag. It needs a SETUP token, then a SETUP-buffer-ready with a chosen direction and length, then a completion-enable write placed after the SETUP (which would otherwise wipe it), and finally one token. The bench sweeps every combination of transfer type, token direction and enable value along that path. It computes the flag and stage outcome from the direction rule. Same-cycle races between a set strobe, a software clear and a SETUP token are forced by driving the bus write and the strobe in one cycle.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_FLAGS = 5;

    // flag bit positions inside the flag register
    localparam int FLG_BUF   = 0;
    localparam int FLG_DONE  = 1;
    localparam int FLG_STS   = 2;
    localparam int FLG_SETUP = 3;
    localparam int FLG_ERR   = 4;

    localparam logic [1:0] MODE_NORMAL = 2'b01;

    typedef enum logic [2:0] {
        STG_IDLE,
        STG_SETUP,
        STG_DOUT,
        STG_DIN,
        STG_STATUS
    } stage_e;

    typedef enum logic [1:0] {
        XFER_NODATA,
        XFER_WRITE,
        XFER_READ
    } xfer_e;

    typedef struct packed {
        logic setup_tok;
        logic setup_rdy;
        logic buf_rdy;
        logic hs_sent;
        logic err;
        logic tok_in;
        logic tok_out;
    } sie_evt_t;

    function automatic xfer_e decode_xfer(input logic dir_in, input logic len_zero);
        if (len_zero)
            return XFER_NODATA;
        else if (dir_in)
            return XFER_READ;
        else
            return XFER_WRITE;
    endfunction

    function automatic stage_e first_stage(input xfer_e kind);
        case (kind)
            XFER_WRITE: return STG_DOUT;
            XFER_READ:  return STG_DIN;
            default:    return STG_STATUS;
        endcase
    endfunction

endpackage

// File: rtl/ctl_ep_stage.sv
module ctl_ep_stage
    import ctl_ep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sie_evt_t evt,
    input  logic     dir_in,
    input  logic     len_zero,
    output stage_e   stage,
    output logic     sts_enter
);

    stage_e stage_q;
    stage_e stage_d;

    always_comb begin
        stage_d   = stage_q;
        sts_enter = 1'b0;
        if (evt.setup_tok) begin
            stage_d = STG_SETUP;
        end else begin
            case (stage_q)
                STG_SETUP: begin
                    if (evt.setup_rdy)
                        stage_d = first_stage(decode_xfer(dir_in, len_zero));
                end
                STG_DOUT: begin
                    if (evt.tok_in) begin
                        stage_d   = STG_STATUS;
                        sts_enter = 1'b1;
                    end
                end
                STG_DIN: begin
                    if (evt.tok_out) begin
                        stage_d   = STG_STATUS;
                        sts_enter = 1'b1;
                    end
                end
                STG_STATUS: begin
                    if (evt.hs_sent)
                        stage_d = STG_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= STG_IDLE;
        else
            stage_q <= stage_d;
    end

    assign stage = stage_q;

endmodule

// File: rtl/ctl_ep_flags.sv
module ctl_ep_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_flag
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (set[i])
                    bit_q <= 1'b1;
                else if (clr[i])
                    bit_q <= 1'b0;
            end
            assign q[i] = bit_q;
        end
    endgenerate

endmodule

// File: rtl/ctl_ep_regif.sv
module ctl_ep_regif
    import ctl_ep_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0,
    parameter int FLAG_ADDR = 1,
    parameter int N         = NUM_FLAGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              setup_tok,
    input  logic [N-1:0]      flags,
    output logic              cmpl_en,
    output logic [N-1:0]      sw_clr,
    output logic [BYTE_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
    localparam int                PAD_W  = BYTE_W - N;

    logic wr_ctrl;
    logic wr_flag;
    logic unused_wdata_hi;

    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign wr_flag = bus_we && (bus_addr == A_FLAG);
    assign unused_wdata_hi = ^bus_wdata[BYTE_W-1:N];

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_clr
            assign sw_clr[i] = wr_flag && !bus_wdata[i];
        end
    endgenerate

    // SETUP withdraws completion permission, over any same-cycle write
    always_ff @(posedge clk) begin
        if (rst)
            cmpl_en <= 1'b0;
        else if (setup_tok)
            cmpl_en <= 1'b0;
        else if (wr_ctrl)
            cmpl_en <= bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_addr == A_CTRL)
            bus_rdata <= {{(BYTE_W-1){1'b0}}, cmpl_en};
        else if (bus_addr == A_FLAG)
            bus_rdata <= {{PAD_W{1'b0}}, flags};
        else
            bus_rdata <= '0;
    end

endmodule

// File: rtl/ctl_ep_events.sv
module ctl_ep_events
    import ctl_ep_pkg::*;
#(
    parameter int                  ADDR_W    = 2,
    parameter int                  CTRL_ADDR = 0,
    parameter int                  FLAG_ADDR = 1,
    parameter logic [NUM_FLAGS-1:0] IRQ_MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sie_setup_tok,
    input  logic              sie_setup_rdy,
    input  logic              sie_dir_in,
    input  logic              sie_len_zero,
    input  logic              sie_buf_rdy,
    input  logic              sie_hs_sent,
    input  logic              sie_err,
    input  logic              sie_tok_in,
    input  logic              sie_tok_out,
    input  logic [1:0]        resp_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              status_ack,
    output logic              in_status
);

    sie_evt_t              evt;
    stage_e                stage;
    logic                  sts_enter;
    logic                  cmpl_en;
    logic [NUM_FLAGS-1:0]  flags;
    logic [NUM_FLAGS-1:0]  flag_set;
    logic [NUM_FLAGS-1:0]  sw_clr;
    logic [NUM_FLAGS-1:0]  flag_clr;

    assign evt = '{setup_tok: sie_setup_tok, setup_rdy: sie_setup_rdy,
                   buf_rdy:   sie_buf_rdy,   hs_sent:   sie_hs_sent,
                   err:       sie_err,       tok_in:    sie_tok_in,
                   tok_out:   sie_tok_out};

    ctl_ep_stage stage_i (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .dir_in   (sie_dir_in),
        .len_zero (sie_len_zero),
        .stage    (stage),
        .sts_enter(sts_enter)
    );

    ctl_ep_regif #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .FLAG_ADDR(FLAG_ADDR),
        .N        (NUM_FLAGS)
    ) regif_i (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .setup_tok(sie_setup_tok),
        .flags    (flags),
        .cmpl_en  (cmpl_en),
        .sw_clr   (sw_clr),
        .bus_rdata(bus_rdata)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLG_BUF]   = sie_buf_rdy;
        flag_set[FLG_DONE]  = sie_hs_sent;
        flag_set[FLG_STS]   = sts_enter && !cmpl_en;
        flag_set[FLG_SETUP] = sie_setup_rdy;
        flag_set[FLG_ERR]   = sie_err;
        flag_clr            = sw_clr;
        flag_clr[FLG_ERR]   = sw_clr[FLG_ERR] || sie_setup_tok;
    end

    ctl_ep_flags #(.N(NUM_FLAGS)) flags_i (
        .clk(clk),
        .rst(rst),
        .set(flag_set),
        .clr(flag_clr),
        .q  (flags)
    );

    assign irq        = |(flags & IRQ_MASK);
    assign status_ack = cmpl_en && (resp_mode == MODE_NORMAL);
    assign in_status  = (stage == STG_STATUS);

endmodule

// File: rtl/ctl_ep_events_chk.sv
module ctl_ep_events_chk
    import ctl_ep_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 sie_setup_tok,
    input logic                 sie_setup_rdy,
    input logic                 sie_len_zero,
    input logic                 sie_buf_rdy,
    input logic                 sie_hs_sent,
    input logic                 sie_err,
    input logic                 sie_tok_in,
    input logic                 cmpl_en,
    input logic [NUM_FLAGS-1:0] flags,
    input stage_e               stage,
    input logic                 irq,
    input logic                 status_ack,
    input logic                 in_status
);

    p_setup_drops_en_r4: assert property (@(posedge clk) disable iff (rst)
        sie_setup_tok |=> !cmpl_en);

    p_nak_when_held_r3: assert property (@(posedge clk) disable iff (rst)
        !cmpl_en |-> !status_ack);

    p_no_sw_set_r6: assert property (@(posedge clk) disable iff (rst)
        (!flags[FLG_BUF] && !sie_buf_rdy) |=> !flags[FLG_BUF]);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        sie_hs_sent |=> flags[FLG_DONE]);

    p_err_kept_r7: assert property (@(posedge clk) disable iff (rst)
        sie_err |=> flags[FLG_ERR]);

    p_irq_source_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));

    p_write_transition_r8: assert property (@(posedge clk) disable iff (rst)
        (stage == STG_DOUT && sie_tok_in && !sie_setup_tok && !cmpl_en) |=> flags[FLG_STS]);

    p_nodata_status_r10: assert property (@(posedge clk) disable iff (rst)
        (stage == STG_SETUP && sie_setup_rdy && sie_len_zero && !sie_setup_tok) |=> in_status);

    p_setup_leaves_status_r10: assert property (@(posedge clk) disable iff (rst)
        sie_setup_tok |=> !in_status);

endmodule

bind ctl_ep_events ctl_ep_events_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .sie_setup_tok(sie_setup_tok),
    .sie_setup_rdy(sie_setup_rdy),
    .sie_len_zero (sie_len_zero),
    .sie_buf_rdy  (sie_buf_rdy),
    .sie_hs_sent  (sie_hs_sent),
    .sie_err      (sie_err),
    .sie_tok_in   (sie_tok_in),
    .cmpl_en      (cmpl_en),
    .flags        (flags),
    .stage        (stage),
    .irq          (irq),
    .status_ack   (status_ack),
    .in_status    (in_status)
);

// File: tb/ctl_ep_events_tb_top.sv
module ctl_ep_events_tb_top;

    localparam int EV_SETUP = 0;
    localparam int EV_SRDY  = 1;
    localparam int EV_BUF   = 2;
    localparam int EV_HS    = 3;
    localparam int EV_ERR   = 4;
    localparam int EV_IN    = 5;
    localparam int EV_OUT   = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sie_setup_tok = 0, sie_setup_rdy = 0, sie_dir_in = 0, sie_len_zero = 0;
    logic       sie_buf_rdy = 0, sie_hs_sent = 0, sie_err = 0, sie_tok_in = 0, sie_tok_out = 0;
    logic [1:0] resp_mode = 2'b01;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, status_ack, in_status;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ctl_ep_events dut_i (
        .clk(clk), .rst(rst),
        .sie_setup_tok(sie_setup_tok), .sie_setup_rdy(sie_setup_rdy),
        .sie_dir_in(sie_dir_in), .sie_len_zero(sie_len_zero),
        .sie_buf_rdy(sie_buf_rdy), .sie_hs_sent(sie_hs_sent), .sie_err(sie_err),
        .sie_tok_in(sie_tok_in), .sie_tok_out(sie_tok_out),
        .resp_mode(resp_mode), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .status_ack(status_ack), .in_status(in_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_ev(input int which, input logic on);
        case (which)
            EV_SETUP: sie_setup_tok = on;
            EV_SRDY:  sie_setup_rdy = on;
            EV_BUF:   sie_buf_rdy   = on;
            EV_HS:    sie_hs_sent   = on;
            EV_ERR:   sie_err       = on;
            EV_IN:    sie_tok_in    = on;
            default:  sie_tok_out   = on;
        endcase
    endtask

    task automatic fire(input int which);
        drive_ev(which, 1'b1);
        @(negedge clk);
        drive_ev(which, 1'b0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic setup_rdy(input logic dir, input logic lz);
        sie_dir_in = dir; sie_len_zero = lz;
        fire(EV_SRDY);
    endtask

    task automatic set_all_flags();
        fire(EV_SETUP);
        setup_rdy(1'b0, 1'b0);
        fire(EV_IN);
        fire(EV_BUF);
        fire(EV_HS);
        fire(EV_ERR);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 status_ack", status_ack, 0);
        chk("R1 in_status", in_status, 0);
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd1, d); chk("R1 flags", d, 0);

        // R2 reserved bits of control register
        wr(2'd0, 8'hFE); rd(2'd0, d); chk("R2 write FE", d, 8'h00);
        wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 write FF", d, 8'h01);

        // R3 status reply sweep over enable and mode
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 4; m++) begin
                wr(2'd0, 8'(en));
                resp_mode = 2'(m);
                @(negedge clk);
                chk("R3 status_ack", status_ack, (en == 1 && m == 1) ? 1 : 0);
            end
        end
        resp_mode = 2'b01;

        // R5 each flag from its strobe
        fire(EV_BUF);   rd(2'd1, d); chk("R5 buf flag", d, 8'h01);
        fire(EV_HS);    rd(2'd1, d); chk("R5 done flag", d, 8'h03);
        fire(EV_SETUP);
        setup_rdy(1'b1, 1'b0); rd(2'd1, d); chk("R5 setup flag", d, 8'h0B);
        fire(EV_ERR);   rd(2'd1, d); chk("R5 err flag", d, 8'h1B);
        chk("R11 irq on", irq, 1);

        // R6 clear sweep, upper bits of write data varied
        for (int w = 0; w < 32; w++) begin
            wr(2'd1, 8'h00);
            set_all_flags();
            rd(2'd1, d); chk("R6 all set", d, 8'h1F);
            wr(2'd1, 8'(w) | 8'(((w * 7) % 8) << 5));
            rd(2'd1, d); chk("R6 keep mask", d, 8'(w));
            chk("R11 irq", irq, (w != 0) ? 1 : 0);
        end
        wr(2'd1, 8'h00);
        wr(2'd1, 8'hFF);
        rd(2'd1, d); chk("R6 write ones no set", d, 8'h00);

        // R7 set beats software clear in the same cycle
        bus_addr = 2'd1; bus_wdata = 8'h00; bus_we = 1'b1; sie_buf_rdy = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; sie_buf_rdy = 1'b0;
        rd(2'd1, d); chk("R7 buf set wins", d, 8'h01);
        wr(2'd1, 8'h00);
        sie_setup_tok = 1'b1; sie_err = 1'b1;
        @(negedge clk);
        sie_setup_tok = 1'b0; sie_err = 1'b0;
        rd(2'd1, d); chk("R7 err set beats setup clear", d, 8'h10);

        // R4 setup token clears enable and error flag
        wr(2'd0, 8'h01);
        fire(EV_BUF);
        fire(EV_SETUP);
        rd(2'd0, d); chk("R4 enable cleared", d, 0);
        chk("R4 status nak", status_ack, 0);
        rd(2'd1, d); chk("R4 err cleared others kept", d, 8'h01);
        bus_addr = 2'd0; bus_wdata = 8'h01; bus_we = 1'b1; sie_setup_tok = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; sie_setup_tok = 1'b0;
        rd(2'd0, d); chk("R4 setup beats write", d, 0);

        // R8 R9 R10 sweep: type x token x enable
        for (int ty = 0; ty < 3; ty++) begin
            for (int tk = 0; tk < 2; tk++) begin
                for (int en = 0; en < 2; en++) begin
                    logic dir, lz, trans;
                    dir = (ty == 1);
                    lz  = (ty == 2);
                    trans = (ty == 0 && tk == 0) || (ty == 1 && tk == 1);
                    wr(2'd1, 8'h00);
                    fire(EV_SETUP);
                    setup_rdy(dir, lz);
                    wr(2'd0, 8'(en));
                    fire(tk == 0 ? EV_IN : EV_OUT);
                    rd(2'd1, d);
                    chk((trans && en == 0) ? "R8 status flag" : "R9 status flag",
                        d & 8'h04, (trans && en == 0) ? 8'h04 : 8'h00);
                    chk("R10 in_status", in_status, (lz || trans) ? 1 : 0);
                    if (lz || trans) begin
                        fire(EV_HS);
                        chk("R10 leave on handshake", in_status, 0);
                    end
                end
            end
        end
        fire(EV_SETUP);
        setup_rdy(1'b0, 1'b1);
        chk("R10 nodata status", in_status, 1);
        fire(EV_SETUP);
        chk("R10 setup leaves status", in_status, 0);

        // R12 registered read, unmapped addresses
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        fire(EV_ERR);
        rd(2'd1, d); chk("R12 flags", d, 8'h10);
        bus_addr = 2'd0;
        #1;
        chk("R12 latency old value", bus_rdata, 8'h10);
        @(negedge clk);
        chk("R12 latency new value", bus_rdata, 8'h01);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        rd(2'd2, d); chk("R12 unmapped 2", d, 0);
        rd(2'd3, d); chk("R12 unmapped 3", d, 0);
        rd(2'd0, d); chk("R12 ctrl untouched", d, 8'h01);
        rd(2'd1, d); chk("R12 flags untouched", d, 8'h10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule